// File: doc/BRIEF.md
# Sector Erase Collection Timer

This block sits in front of the erase engine of a sectored non-volatile array. Sector-erase commands arrive one at a time, each with a sector index. The block collects them into a pending sector mask. A window timer restarts on every such command. When the window runs out with no further request, the block fires a one-cycle erase-start pulse that carries the collected mask and runs a busy phase. The busy phase is modelled as a counter of a fixed number of cycles per selected sector.

Sectors are protected in groups of neighbouring sectors, and a protection map holds one bit per group. A request for a sector in a protected group still counts as a sector-erase command, so it restarts the window, but its bit never enters the mask. Any other command that arrives while the window is open throws the whole collection away and pulses an abort-to-read strobe. A suspend command freezes the erase. If the suspend arrives inside the window, the window closes at once and the erase waits, already suspended, until a resume. Once the erase runs, the block ignores every command except suspend.

Top module: `sect_erase_collect`

## Requirements
- R1: After reset the pending mask is zero and the window-open, erase-start, suspended and abort outputs are all low.
- R2: In the idle state, a sector-erase request opens the window on the next cycle. If the sector is unprotected, bit i of the pending mask (bit i stands for sector i) is set.
- R3: Sector i belongs to group i / GRP_SIZE, and bit g of the protection map set to 1 marks group g as protected. A request for a protected sector never sets its mask bit, whether it arrives in idle or inside the window.
- R4: The window stays open for exactly WIN_CYCLES cycles after the clock edge that accepts the most recent sector-erase request. In the cycle after that, erase_go is high for one cycle and the pending mask holds the collected sectors.
- R5: A sector-erase request that arrives while the window is open adds its sector to the mask and restarts the full window. A protected request also restarts the window.
- R6: Another command that arrives while the window is open clears the mask and closes the window, and abort_rd pulses high for one cycle. Another command that arrives in idle has no effect.
- R7: A suspend that arrives while the window is open closes the window at once and raises the suspended flag, and the erase does not start. The next resume gives the erase_go pulse with the collected mask.
- R8: A suspend during the busy phase freezes the busy count until a resume, so the erase still takes its full number of running cycles.
- R9: The busy phase lasts the number of mask bits times ERASE_CYC cycles after erase_go, and then the mask clears. During the busy phase, sector-erase requests, other commands and repeated resumes leave the mask unchanged and give no abort.
- R10: If the window closes with an empty mask because every requested sector was protected, erase_go still pulses and the block returns to idle at once. A request in the very next cycle opens a new window.
- R11: When several strobes arrive in the same window cycle, suspend wins over another command, and another command wins over a sector-erase request.
- R12: A resume or suspend that arrives in idle is ignored. No erase_go pulse follows and the suspended flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| se_req | input | 1 | Sector-erase command strobe |
| se_idx | input | IDX_W | Sector index of the request |
| cmd_other | input | 1 | Strobe for any command other than sector erase |
| susp_req | input | 1 | Suspend command strobe |
| resm_req | input | 1 | Resume command strobe |
| prot_map | input | NUM_GRP | Protection bit per sector group, 1 = protected |
| pend_mask | output | NUM_SECT | Collected sectors, held until the erase completes |
| win_open | output | 1 | Collection window is running |
| erase_go | output | 1 | One-cycle erase-start pulse |
| susp_flag | output | 1 | Erase or window is suspended |
| abort_rd | output | 1 | One-cycle pulse when a collection is discarded |

## Verification
The hardest state to reach is a suspend that lands inside the busy phase after the count has partly run down, followed by a resume. The end time then depends on how many running cycles had already passed. The bench lets a known number of cycles elapse after erase_go and then pulses suspend. It holds the suspend for several cycles, checking that the mask stays put, and then resumes with a second, redundant resume. It predicts the completion cycle from the count of running cycles that remain. A second hard case is a window that closes with only protected requests. This needs a protection map set up beforehand and a request issued in the cycle right after the empty start pulse.

// File: rtl/secq_pkg.sv
package secq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WIN   = 2'd1,
    ST_ERASE = 2'd2,
    ST_SUSP  = 2'd3
  } secq_state_e;

  // group that owns a sector
  function automatic int unsigned grp_of(input int unsigned sect, input int unsigned grp_size);
    return sect / grp_size;
  endfunction

  // busy length: selected sectors times cycles per sector
  function automatic int unsigned busy_len(input logic [63:0] m, input int unsigned per_sect);
    int unsigned n;
    n = 0;
    for (int b = 0; b < 64; b++) n += int'(m[b]);
    return n * per_sect;
  endfunction

endpackage

// File: rtl/secq_filter.sv
module secq_filter #(
  parameter int NUM_SECT = 16,
  parameter int GRP_SIZE = 2,
  localparam int NUM_GRP = NUM_SECT / GRP_SIZE,
  localparam int IDX_W   = $clog2(NUM_SECT)
) (
  input  logic [IDX_W-1:0]    idx,
  input  logic [NUM_GRP-1:0]  prot_map,
  output logic [NUM_SECT-1:0] req_bit
);
  logic [NUM_SECT-1:0] sect_prot;

  for (genvar i = 0; i < NUM_SECT; i++) begin : g_prot
    assign sect_prot[i] = prot_map[secq_pkg::grp_of(i, GRP_SIZE)];
  end

  logic [NUM_SECT-1:0] onehot;
  assign onehot  = {{(NUM_SECT-1){1'b0}}, 1'b1} << idx;
  assign req_bit = onehot & ~sect_prot;
endmodule

// File: rtl/secq_win_timer.sv
module secq_win_timer #(
  parameter int WIN_CYCLES = 12500,
  localparam int TMR_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clear,
  output logic run,
  output logic expire
);
  logic [TMR_W-1:0] tmr;

  assign expire = run && (tmr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      tmr <= '0;
    end else if (load) begin
      run <= 1'b1;
      tmr <= TMR_W'(WIN_CYCLES - 1);
    end else if (clear || expire) begin
      run <= 1'b0;
    end else if (run) begin
      tmr <= tmr - 1'b1;
    end
  end

  // R5
  win_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (run && tmr == TMR_W'(WIN_CYCLES - 1)));

  // R4
  win_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> !run);
endmodule

// File: rtl/secq_busy_ctr.sv
module secq_busy_ctr #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  assign zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt));
endmodule

// File: rtl/sect_erase_collect.sv
module sect_erase_collect #(
  parameter int NUM_SECT   = 16,
  parameter int GRP_SIZE   = 2,
  parameter int WIN_CYCLES = 12500,
  parameter int ERASE_CYC  = 1000,
  localparam int NUM_GRP = NUM_SECT / GRP_SIZE,
  localparam int IDX_W   = $clog2(NUM_SECT),
  localparam int CNT_W   = $clog2(NUM_SECT * ERASE_CYC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                se_req,
  input  logic [IDX_W-1:0]    se_idx,
  input  logic                cmd_other,
  input  logic                susp_req,
  input  logic                resm_req,
  input  logic [NUM_GRP-1:0]  prot_map,
  output logic [NUM_SECT-1:0] pend_mask,
  output logic                win_open,
  output logic                erase_go,
  output logic                susp_flag,
  output logic                abort_rd
);
  import secq_pkg::*;

  secq_state_e         state;
  logic                begun;
  logic [NUM_SECT-1:0] req_bit;
  logic                tmr_load, tmr_clr, tmr_run, tmr_exp;
  logic                bsy_load, bsy_run, bsy_zero;
  logic [CNT_W-1:0]    bsy_val;
  logic                erasing, erase_done, mask_empty;

  secq_filter #(.NUM_SECT(NUM_SECT), .GRP_SIZE(GRP_SIZE)) u_filt (
    .idx(se_idx), .prot_map(prot_map), .req_bit(req_bit));

  secq_win_timer #(.WIN_CYCLES(WIN_CYCLES)) u_win (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .clear(tmr_clr),
    .run(tmr_run), .expire(tmr_exp));

  secq_busy_ctr #(.CNT_W(CNT_W)) u_busy (
    .clk(clk), .rst_n(rst_n), .load(bsy_load), .load_val(bsy_val),
    .run(bsy_run), .zero(bsy_zero));

  assign mask_empty = (pend_mask == '0);
  assign bsy_val    = CNT_W'(busy_len(64'(pend_mask), ERASE_CYC) - 1);
  assign erasing    = (state == ST_ERASE);
  assign erase_done = erasing && bsy_zero;
  assign bsy_run    = erasing && !susp_req;
  assign win_open   = (state == ST_WIN);
  assign susp_flag  = (state == ST_SUSP);

  always_comb begin
    tmr_load = 1'b0;
    tmr_clr  = 1'b0;
    bsy_load = 1'b0;
    case (state)
      ST_IDLE: tmr_load = se_req;
      ST_WIN: begin
        if (susp_req || cmd_other) tmr_clr  = 1'b1;
        else if (se_req)           tmr_load = 1'b1;
        else if (tmr_exp)          bsy_load = !mask_empty;
      end
      ST_SUSP: bsy_load = resm_req && !begun && !mask_empty;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pend_mask <= '0;
      begun     <= 1'b0;
      erase_go  <= 1'b0;
      abort_rd  <= 1'b0;
    end else begin
      erase_go <= 1'b0;
      abort_rd <= 1'b0;
      case (state)
        ST_IDLE: begin
          begun <= 1'b0;
          if (se_req) begin
            state     <= ST_WIN;
            pend_mask <= req_bit;
          end
        end
        ST_WIN: begin
          if (susp_req) begin
            state <= ST_SUSP;
          end else if (cmd_other) begin
            state     <= ST_IDLE;
            pend_mask <= '0;
            abort_rd  <= 1'b1;
          end else if (se_req) begin
            pend_mask <= pend_mask | req_bit;
          end else if (tmr_exp) begin
            erase_go <= 1'b1;
            begun    <= 1'b1;
            state    <= mask_empty ? ST_IDLE : ST_ERASE;
          end
        end
        ST_ERASE: begin
          if (susp_req) begin
            state <= ST_SUSP;
          end else if (erase_done) begin
            state     <= ST_IDLE;
            pend_mask <= '0;
          end
        end
        ST_SUSP: begin
          if (resm_req) begin
            if (!begun) begin
              erase_go <= 1'b1;
              begun    <= 1'b1;
              state    <= mask_empty ? ST_IDLE : ST_ERASE;
            end else begin
              state <= ST_ERASE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> !erase_go);

  // R6
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_rd |-> (mask_empty && !win_open && !tmr_run));

  // R7
  susp_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    susp_flag |-> (!win_open && !tmr_run));

  // R9
  erase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erasing && $past(erasing)) |-> $stable(pend_mask));

  // R2
  win_timer_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> tmr_run);
endmodule

// File: tb/sect_erase_collect_test.sv
module sect_erase_collect_test;
  localparam int NS  = 16;
  localparam int GS  = 2;
  localparam int W   = 10;
  localparam int EC  = 4;
  localparam int NG  = NS / GS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          se_req = 1'b0;
  logic [3:0]    se_idx = '0;
  logic          cmd_other = 1'b0;
  logic          susp_req = 1'b0;
  logic          resm_req = 1'b0;
  logic [NG-1:0] prot_map = '0;
  logic [NS-1:0] pend_mask;
  logic          win_open, erase_go, susp_flag, abort_rd;

  int vecs = 0;
  int miss = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sect_erase_collect #(.NUM_SECT(NS), .GRP_SIZE(GS), .WIN_CYCLES(W), .ERASE_CYC(EC)) uut (
    .clk(clk), .rst_n(rst_n), .se_req(se_req), .se_idx(se_idx),
    .cmd_other(cmd_other), .susp_req(susp_req), .resm_req(resm_req),
    .prot_map(prot_map), .pend_mask(pend_mask), .win_open(win_open),
    .erase_go(erase_go), .susp_flag(susp_flag), .abort_rd(abort_rd));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // all pulse tasks start and end at a falling edge
  task automatic req(input int s);
    se_req = 1'b1; se_idx = 4'(s);
    @(negedge clk);
    se_req = 1'b0;
  endtask

  task automatic pulse(input bit sp, input bit ot, input bit rs);
    susp_req = sp; cmd_other = ot; resm_req = rs;
    @(negedge clk);
    susp_req = 1'b0; cmd_other = 1'b0; resm_req = 1'b0;
  endtask

  // erase_go sampled at the current edge; mask lasts nsect*EC cycles from there
  task automatic finish_erase(input string tag, input logic [NS-1:0] m, input int used);
    int l;
    l = $countones(m) * EC;
    wait_n(l - 1 - used);
    chk({tag, " mask held"}, 32'(pend_mask), 32'(m));
    wait_n(1);
    chk({tag, " mask cleared"}, 32'(pend_mask), 0);
  endtask

  task automatic t_reset();
    chk("R1 mask", 32'(pend_mask), 0);
    chk("R1 flags", {win_open, erase_go, susp_flag, abort_rd}, 0);
  endtask

  task automatic t_single();
    req(9);
    chk("R2 win_open", 32'(win_open), 1);
    chk("R2 mask bit", 32'(pend_mask), 32'h0200);
    wait_n(W - 1);
    chk("R4 still open", {win_open, erase_go}, 2'b10);
    wait_n(1);
    chk("R4 go pulse", {win_open, erase_go}, 2'b01);
    chk("R4 go mask", 32'(pend_mask), 32'h0200);
    wait_n(1);
    chk("R4 go one cycle", 32'(erase_go), 0);
    finish_erase("R9 single", 16'h0200, 1);
  endtask

  task automatic t_restart();
    req(2);
    wait_n(5);
    req(7);
    chk("R5 added", 32'(pend_mask), 32'h0084);
    wait_n(W - 1);
    chk("R5 window restarted", {win_open, erase_go}, 2'b10);
    wait_n(1);
    chk("R5 go", {erase_go, 16'(pend_mask)}, {1'b1, 16'h0084});
    se_req = 1'b1; se_idx = 4'd0;
    pulse(1'b0, 1'b1, 1'b1);
    se_req = 1'b0;
    chk("R9 ignored in erase", {abort_rd, win_open, 16'(pend_mask)}, {2'b00, 16'h0084});
    finish_erase("R9 two sectors", 16'h0084, 1);
  endtask

  task automatic t_abort();
    req(3);
    wait_n(2);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R6 abort", {abort_rd, win_open, 16'(pend_mask)}, {2'b10, 16'h0});
    wait_n(1);
    chk("R6 abort one cycle", 32'(abort_rd), 0);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R6 idle other ignored", {abort_rd, win_open}, 0);
  endtask

  task automatic t_prot();
    prot_map = 8'h04;
    req(5);
    chk("R3 protected idle", {win_open, 16'(pend_mask)}, {1'b1, 16'h0});
    wait_n(W - 1);
    wait_n(1);
    chk("R10 empty go", {erase_go, 16'(pend_mask)}, {1'b1, 16'h0});
    req(1);
    chk("R10 reopen", {win_open, 16'(pend_mask)}, {1'b1, 16'h0002});
    req(4);
    chk("R3 protected in window", 32'(pend_mask), 32'h0002);
    req(3);
    chk("R3 neighbour group", 32'(pend_mask), 32'h000A);
    pulse(1'b0, 1'b1, 1'b0);
    prot_map = '0;
  endtask

  task automatic t_win_susp();
    req(6);
    wait_n(2);
    pulse(1'b1, 1'b0, 1'b0);
    chk("R7 suspended", {susp_flag, win_open, 16'(pend_mask)}, {2'b10, 16'h0040});
    wait_n(W + 3);
    chk("R7 no go", {erase_go, susp_flag}, 2'b01);
    pulse(1'b0, 1'b0, 1'b1);
    chk("R7 resume go", {erase_go, susp_flag, 16'(pend_mask)}, {2'b10, 16'h0040});
    finish_erase("R7 erase", 16'h0040, 0);
  endtask

  task automatic t_erase_susp();
    req(10);
    req(11);
    wait_n(W);
    chk("R8 go", {erase_go, 16'(pend_mask)}, {1'b1, 16'h0C00});
    wait_n(3);
    pulse(1'b1, 1'b0, 1'b0);
    chk("R8 suspended", 32'(susp_flag), 1);
    wait_n(5);
    chk("R8 frozen", {susp_flag, 16'(pend_mask)}, {1'b1, 16'h0C00});
    pulse(1'b0, 1'b0, 1'b1);
    chk("R8 resumed", {susp_flag, erase_go}, 0);
    pulse(1'b0, 1'b0, 1'b1);
    // running edges left after resume: 2*EC - 3; one used by second resume
    wait_n(2 * EC - 5);
    chk("R8 remaining held", 32'(pend_mask), 32'h0C00);
    wait_n(1);
    chk("R8 completes on time", 32'(pend_mask), 0);
  endtask

  task automatic t_prio();
    req(12);
    se_req = 1'b1; se_idx = 4'd13;
    pulse(1'b1, 1'b1, 1'b0);
    se_req = 1'b0;
    chk("R11 suspend wins", {susp_flag, abort_rd, 16'(pend_mask)}, {2'b10, 16'h1000});
    pulse(1'b0, 1'b0, 1'b1);
    chk("R11 resume go", {erase_go, 16'(pend_mask)}, {1'b1, 16'h1000});
    finish_erase("R11 erase", 16'h1000, 0);
    req(14);
    se_req = 1'b1; se_idx = 4'd15;
    pulse(1'b0, 1'b1, 1'b0);
    se_req = 1'b0;
    chk("R11 other beats request", {abort_rd, 16'(pend_mask)}, {1'b1, 16'h0});
  endtask

  task automatic t_idle_strobes();
    wait_n(1);
    pulse(1'b0, 1'b0, 1'b1);
    chk("R12 resume idle", {erase_go, susp_flag, win_open}, 0);
    pulse(1'b1, 1'b0, 1'b0);
    chk("R12 suspend idle", {erase_go, susp_flag, win_open}, 0);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_single();
    t_restart();
    t_abort();
    t_prot();
    t_win_susp();
    t_erase_susp();
    t_prio();
    t_idle_strobes();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vecs++;
      miss++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end
endmodule